// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block decides what happens to one bus transfer descriptor after the device has answered. A request carries three things: the descriptor's 32-bit control word, its 32-bit token, and the device's response code with a byte count. From these the block works out the new control word. It also produces a two-bit interrupt-cause contribution and one of three outcomes. The outcomes are: advance the queue to the next descriptor, skip (leave the queue where it is), or abort the rest of the frame. Alongside the result it raises an error flag and a process-error flag for the controller's status logic, and a flag that says whether the control word must be written back to memory.

The schedule walker presents a request on a valid/ready channel. Ready is low while reset is applied and high at all other times, so the block never applies back-pressure. A request is taken on every clock edge where both valid and ready are high. The request fields need only be stable in that cycle. The result appears on registered outputs in the next cycle, together with a one-cycle done strobe. The result holds its value until the next request is taken. There is no back-pressure on the result side, so the walker must capture it in the done cycle.

Control word bits used: 23 active, 24 interrupt on complete, 25 isochronous, 29 short-packet detect, 22 stall, 20 babble, 19 NAK, 18 timeout, 28:27 retry count, 10:0 actual length minus one. Token fields used: 7:0 packet identifier, 31:21 maximum length minus one.

Top module: `td_status_unit`

## Requirements
- R1: After reset, done, res_mask, res_outcome, res_err, res_perr, res_wb and res_ctrl are zero. Ready is high from the first edge after reset release. Each accepted request produces exactly one done pulse, one cycle after acceptance.
- R2: The maximum length is (token[31:21] + 1) modulo 2048. A field of 0x7FF therefore means a maximum of zero. The identifier in token[7:0] is SETUP for 0x2D, IN for 0x69 and OUT for 0xE1.
- R3: Control bit 24 always sets res_mask[0], including when the descriptor is inactive. When control bit 23 is clear, the outcome is skip (code 1), the control word is returned unchanged, and no flag other than res_mask[0] is raised.
- R4: An active descriptor whose identifier is none of SETUP, IN or OUT raises res_perr and gives outcome abort (code 2). The control word is returned unchanged.
- R5: Response codes are ACK 0, NAK 1, STALL 2, NO-DEVICE 3 and BABBLE 4. The codes 5 to 7 act as NO-DEVICE. For an ACK, bits 10:0 become (length - 1) modulo 2048, active is cleared, and the outcome is advance (code 0). The length is the response byte count for IN and the maximum length for SETUP and OUT.
- R6: An ACKed IN with bit 29 set and a byte count below the maximum sets res_mask[1] and gives skip instead of advance.
- R7: An IN ACK whose byte count exceeds the maximum is treated as babble, as is a BABBLE response. Babble sets bits 20 and 22, clears active and gives abort. The length field is not touched.
- R8: NO-DEVICE, or NAK on a SETUP token, sets bit 18 and gives skip. A non-zero retry count is decremented. A decrement to zero clears active and raises res_err. A zero count stays zero.
- R9: A NAK on IN or OUT sets bit 19, keeps active and gives skip. A NAK on SETUP sets bit 19 in addition to following R8.
- R10: A STALL sets bit 22, clears active and gives skip.
- R11: With bit 25 set on an active descriptor with a valid identifier, active is cleared whatever the response.
- R12: res_wb is high in the done cycle exactly when res_ctrl differs from the control word that was supplied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (high outside reset) |
| req_ctrl | input | 32 | Descriptor control word |
| req_token | input | 32 | Descriptor token |
| req_resp | input | 3 | Device response code |
| req_len | input | LEN_W (12) | Byte count returned by the device |
| done | output | 1 | One-cycle strobe: result valid |
| res_ctrl | output | 32 | Updated control word |
| res_mask | output | 2 | Interrupt causes: bit 0 complete, bit 1 short packet |
| res_outcome | output | 2 | 0 advance, 1 skip, 2 abort |
| res_wb | output | 1 | Control word changed, write-back needed |
| res_err | output | 1 | Retry count exhausted |
| res_perr | output | 1 | Invalid identifier, process error |

## Verification
Every result, including the flags, comes from the single output register. All of it is therefore due in the cycle after the edge that takes the request, and done falls one cycle after that. The bench drives each request on a falling edge and holds valid for one edge. It compares every output field at the next falling edge, where done must be high. In selected cases it also checks at the falling edge after that, confirming that done has dropped. Random requests are mixed with directed corners: retry count 1 and 0, a maximum-length field of 0x7FF, byte counts one above and one below the maximum, and NAK on SETUP.

// File: rtl/td_pkg.sv
package td_pkg;
  localparam int CTRL_W   = 32;
  localparam int LENF_W   = 11;

  localparam int B_ACT    = 23;
  localparam int B_IOC    = 24;
  localparam int B_ISO    = 25;
  localparam int B_SPD    = 29;
  localparam int B_STALL  = 22;
  localparam int B_BABBLE = 20;
  localparam int B_NAK    = 19;
  localparam int B_TMO    = 18;
  localparam int B_CNT_LO = 27;
  localparam int B_CNT_HI = 28;

  localparam logic [7:0] ID_SETUP = 8'h2D;
  localparam logic [7:0] ID_IN    = 8'h69;
  localparam logic [7:0] ID_OUT   = 8'hE1;

  localparam logic [2:0] RSP_ACK    = 3'd0;
  localparam logic [2:0] RSP_NAK    = 3'd1;
  localparam logic [2:0] RSP_STALL  = 3'd2;
  localparam logic [2:0] RSP_NODEV  = 3'd3;
  localparam logic [2:0] RSP_BABBLE = 3'd4;

  typedef enum logic [1:0] {
    OC_ADVANCE = 2'd0,
    OC_SKIP    = 2'd1,
    OC_ABORT   = 2'd2
  } outcome_e;

  typedef enum logic [1:0] {
    KIND_BAD   = 2'd0,
    KIND_SETUP = 2'd1,
    KIND_IN    = 2'd2,
    KIND_OUT   = 2'd3
  } pkt_kind_e;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic [1:0]        mask;
    outcome_e          outcome;
    logic              err;
    logic              perr;
    logic              wb;
  } td_result_t;
endpackage

// File: rtl/td_token_decode.sv
module td_token_decode
  import td_pkg::*;
(
  input  logic [31:0]       token,
  output logic [LENF_W-1:0] max_len,
  output pkt_kind_e         kind
);
  // Length field holds max-1; the sum wraps so 0x7FF means zero bytes.
  assign max_len = token[31:21] + LENF_W'(1);

  always_comb begin
    case (token[7:0])
      ID_SETUP: kind = KIND_SETUP;
      ID_IN:    kind = KIND_IN;
      ID_OUT:   kind = KIND_OUT;
      default:  kind = KIND_BAD;
    endcase
  end
endmodule

// File: rtl/td_resp_eval.sv
module td_resp_eval
  import td_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic [2:0]        resp,
  input  logic [LEN_W-1:0]  len,
  input  logic [LENF_W-1:0] max_len,
  input  pkt_kind_e         kind,
  output logic [2:0]        eff_resp,
  output logic [LENF_W-1:0] xfer_len,
  output logic              short_pkt
);
  localparam int CMP_W = (LEN_W > LENF_W) ? LEN_W : LENF_W;

  logic [CMP_W-1:0] len_x;
  logic [CMP_W-1:0] max_x;
  logic             over;

  assign len_x = CMP_W'(len);
  assign max_x = CMP_W'(max_len);
  assign over  = len_x > max_x;

  always_comb begin
    eff_resp  = (resp > RSP_BABBLE) ? RSP_NODEV : resp;
    xfer_len  = max_len;
    short_pkt = 1'b0;
    if (kind == KIND_IN) begin
      if (resp == RSP_ACK) begin
        if (over) begin
          eff_resp = RSP_BABBLE;
        end else begin
          xfer_len  = len_x[LENF_W-1:0];
          short_pkt = len_x < max_x;
        end
      end
    end
  end
endmodule

// File: rtl/td_ctrl_update.sv
module td_ctrl_update
  import td_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl,
  input  pkt_kind_e         kind,
  input  logic [2:0]        eff_resp,
  input  logic [LENF_W-1:0] xfer_len,
  input  logic              short_pkt,
  output td_result_t        res
);
  logic [CTRL_W-1:0] nxt;
  logic [1:0]        mask;
  outcome_e          oc;
  logic              err;
  logic              perr;
  logic              tmo;
  logic [1:0]        cnt;

  assign cnt = ctrl[B_CNT_HI:B_CNT_LO];

  always_comb begin
    nxt  = ctrl;
    mask = {1'b0, ctrl[B_IOC]};
    oc   = OC_SKIP;
    err  = 1'b0;
    perr = 1'b0;
    tmo  = 1'b0;
    if (ctrl[B_ACT]) begin
      if (kind == KIND_BAD) begin
        perr = 1'b1;
        oc   = OC_ABORT;
      end else begin
        if (ctrl[B_ISO]) nxt[B_ACT] = 1'b0;
        case (eff_resp)
          RSP_ACK: begin
            nxt[LENF_W-1:0] = xfer_len - LENF_W'(1);
            nxt[B_ACT]      = 1'b0;
            if (kind == KIND_IN && ctrl[B_SPD] && short_pkt) begin
              mask[1] = 1'b1;
              oc      = OC_SKIP;
            end else begin
              oc = OC_ADVANCE;
            end
          end
          RSP_NAK: begin
            nxt[B_NAK] = 1'b1;
            tmo        = (kind == KIND_SETUP);
          end
          RSP_STALL: begin
            nxt[B_STALL] = 1'b1;
            nxt[B_ACT]   = 1'b0;
          end
          RSP_BABBLE: begin
            nxt[B_BABBLE] = 1'b1;
            nxt[B_STALL]  = 1'b1;
            nxt[B_ACT]    = 1'b0;
            oc            = OC_ABORT;
          end
          default: tmo = 1'b1;
        endcase
        if (tmo) begin
          nxt[B_TMO] = 1'b1;
          if (cnt != 2'd0) begin
            nxt[B_CNT_HI:B_CNT_LO] = cnt - 2'd1;
            if (cnt == 2'd1) begin
              nxt[B_ACT] = 1'b0;
              err        = 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    res.ctrl    = nxt;
    res.mask    = mask;
    res.outcome = oc;
    res.err     = err;
    res.perr    = perr;
    res.wb      = (nxt != ctrl);
  end
endmodule

// File: rtl/td_status_unit.sv
module td_status_unit
  import td_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_ctrl,
  input  logic [31:0]      req_token,
  input  logic [2:0]       req_resp,
  input  logic [LEN_W-1:0] req_len,
  output logic             done,
  output logic [31:0]      res_ctrl,
  output logic [1:0]       res_mask,
  output logic [1:0]       res_outcome,
  output logic             res_wb,
  output logic             res_err,
  output logic             res_perr
);
  logic [LENF_W-1:0] max_len;
  pkt_kind_e         kind;
  logic [2:0]        eff_resp;
  logic [LENF_W-1:0] xfer_len;
  logic              short_pkt;
  td_result_t        nxt_res;
  td_result_t        res_q;
  logic              ready_q;
  logic              done_q;
  logic              take;

  td_token_decode u_dec (
    .token   (req_token),
    .max_len (max_len),
    .kind    (kind)
  );

  td_resp_eval #(.LEN_W(LEN_W)) u_eval (
    .resp      (req_resp),
    .len       (req_len),
    .max_len   (max_len),
    .kind      (kind),
    .eff_resp  (eff_resp),
    .xfer_len  (xfer_len),
    .short_pkt (short_pkt)
  );

  td_ctrl_update u_upd (
    .ctrl      (req_ctrl),
    .kind      (kind),
    .eff_resp  (eff_resp),
    .xfer_len  (xfer_len),
    .short_pkt (short_pkt),
    .res       (nxt_res)
  );

  assign take = req_valid && ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      done_q  <= take;
      if (take) res_q <= nxt_res;
    end
  end

  assign req_ready   = ready_q;
  assign done        = done_q;
  assign res_ctrl    = res_q.ctrl;
  assign res_mask    = res_q.mask;
  assign res_outcome = res_q.outcome;
  assign res_wb      = res_q.wb;
  assign res_err     = res_q.err;
  assign res_perr    = res_q.perr;

  // Timing of the result strobe.
  p_done_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req_valid && req_ready));
  p_no_spurious_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !done);
  // Process error always aborts and never touches the word.
  p_perr_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_perr) |-> (res_outcome == 2'd2 && res_ctrl == $past(req_ctrl)));
  // Short-packet cause only with a skip.
  p_short_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_mask[1]) |-> (res_outcome == 2'd1));
  // Non-process aborts carry babble and stall marks.
  p_abort_babble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_outcome == 2'd2 && !res_perr) |-> (res_ctrl[20] && res_ctrl[22] && !res_ctrl[23]));
  // Exhausted retries leave the descriptor inactive with timeout set.
  p_err_inactive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_err) |-> (!res_ctrl[23] && res_ctrl[18] && res_ctrl[28:27] == 2'd0));
  // Write-back flag matches an actual change.
  p_wb_change_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_wb == (res_ctrl != $past(req_ctrl))));
  // Isochronous descriptors never stay active after processing.
  p_iso_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res_perr && $past(req_ctrl[25])) |-> !res_ctrl[23]);
endmodule

// File: tb/td_status_unit_tb_top.sv
module td_status_unit_tb_top;
  localparam int LW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [31:0]   req_ctrl = '0;
  logic [31:0]   req_token = '0;
  logic [2:0]    req_resp = '0;
  logic [LW-1:0] req_len = '0;
  logic          done;
  logic [31:0]   res_ctrl;
  logic [1:0]    res_mask;
  logic [1:0]    res_outcome;
  logic          res_wb, res_err, res_perr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  td_status_unit #(.LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ctrl(req_ctrl), .req_token(req_token), .req_resp(req_resp), .req_len(req_len),
    .done(done), .res_ctrl(res_ctrl), .res_mask(res_mask), .res_outcome(res_outcome),
    .res_wb(res_wb), .res_err(res_err), .res_perr(res_perr)
  );

  typedef struct packed {
    logic [31:0] ctrl;
    logic [1:0]  mask;
    logic [1:0]  oc;
    logic        err;
    logic        perr;
    logic        wb;
  } exp_t;

  function automatic exp_t model(input logic [31:0] c, input logic [31:0] t,
                                 input logic [2:0] r, input logic [LW-1:0] n);
    exp_t e;
    logic [10:0] mx;
    logic [7:0]  id;
    logic [2:0]  rr;
    logic [10:0] ln;
    logic        to;
    e = '0;
    e.ctrl = c;
    e.mask[0] = c[24];
    e.oc = 2'd1;
    mx = t[31:21] + 11'd1;
    id = t[7:0];
    rr = (r > 3'd4) ? 3'd3 : r;
    ln = mx;
    to = 1'b0;
    if (c[23]) begin
      if (id != 8'h2D && id != 8'h69 && id != 8'hE1) begin
        e.perr = 1'b1;
        e.oc = 2'd2;
      end else begin
        if (c[25]) e.ctrl[23] = 1'b0;
        if (id == 8'h69 && r == 3'd0) begin
          if ({1'b0, n} > {2'b0, mx}) rr = 3'd4;
          else ln = n[10:0];
        end
        if (rr == 3'd0) begin
          e.ctrl[10:0] = ln - 11'd1;
          e.ctrl[23] = 1'b0;
          if (id == 8'h69 && c[29] && ln < mx) begin
            e.mask[1] = 1'b1;
            e.oc = 2'd1;
          end else e.oc = 2'd0;
        end else if (rr == 3'd1) begin
          e.ctrl[19] = 1'b1;
          to = (id == 8'h2D);
        end else if (rr == 3'd2) begin
          e.ctrl[22] = 1'b1;
          e.ctrl[23] = 1'b0;
        end else if (rr == 3'd4) begin
          e.ctrl[20] = 1'b1;
          e.ctrl[22] = 1'b1;
          e.ctrl[23] = 1'b0;
          e.oc = 2'd2;
        end else to = 1'b1;
        if (to) begin
          e.ctrl[18] = 1'b1;
          if (c[28:27] != 2'd0) begin
            e.ctrl[28:27] = c[28:27] - 2'd1;
            if (c[28:27] == 2'd1) begin
              e.ctrl[23] = 1'b0;
              e.err = 1'b1;
            end
          end
        end
      end
    end
    e.wb = (e.ctrl != c);
    return e;
  endfunction

  function automatic string tag_of(input logic [31:0] c, input logic [31:0] t,
                                   input logic [2:0] r, input logic [LW-1:0] n);
    logic [7:0]  id;
    logic [10:0] mx;
    id = t[7:0];
    mx = t[31:21] + 11'd1;
    if (!c[23]) return "R3";
    if (id != 8'h2D && id != 8'h69 && id != 8'hE1) return "R4";
    if (c[25]) return "R11";
    if (r == 3'd4 || (id == 8'h69 && r == 3'd0 && {1'b0, n} > {2'b0, mx})) return "R7";
    if (r == 3'd0 && id == 8'h69 && c[29] && n[10:0] < mx) return "R6";
    if (r == 3'd0) return "R5";
    if (r == 3'd1 && id != 8'h2D) return "R9";
    if (r == 3'd2) return "R10";
    return "R8";
  endfunction

  task automatic run(input logic [31:0] c, input logic [31:0] t, input logic [2:0] r,
                     input logic [LW-1:0] n, input string tag);
    exp_t e;
    e = model(c, t, r, n);
    @(negedge clk);
    req_ctrl = c; req_token = t; req_resp = r; req_len = n; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (!done || res_ctrl != e.ctrl || res_mask != e.mask || res_outcome != e.oc ||
        res_err != e.err || res_perr != e.perr || res_wb != e.wb) begin
      errors++;
      $display("FAIL %s: done=%b ctrl=%h mask=%b oc=%0d err=%b perr=%b wb=%b expected done=1 ctrl=%h mask=%b oc=%0d err=%b perr=%b wb=%b",
               tag, done, res_ctrl, res_mask, res_outcome, res_err, res_perr, res_wb,
               e.ctrl, e.mask, e.oc, e.err, e.perr, e.wb);
    end
  endtask

  task automatic check_done_low(input string tag);
    @(negedge clk);
    checks++;
    if (done !== 1'b0) begin
      errors++;
      $display("FAIL %s: done=%b expected 0 one cycle after the strobe", tag, done);
    end
  endtask

  function automatic logic [31:0] tok(input logic [7:0] id, input logic [10:0] mf);
    return {mf, 2'b0, 4'd1, 7'd5, id};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 1'b0 || res_ctrl !== 32'h0 || res_mask !== 2'b0 || res_outcome !== 2'd0 ||
        res_wb !== 1'b0 || res_err !== 1'b0 || res_perr !== 1'b0 || req_ready !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset outputs done=%b ctrl=%h ready=%b expected all zero", done, res_ctrl, req_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1: ready=%b expected 1", req_ready);
    end
    // R3 inactive with interrupt-on-complete
    run(32'h0100_0000, tok(8'h69, 11'd7), 3'd0, 12'd3, "R3");
    check_done_low("R1");
    // R4 bad identifier
    run(32'h0180_0000, tok(8'h55, 11'd7), 3'd0, 12'd3, "R4");
    // R5 OUT ack uses maximum; R2 field 0x7FF means zero length
    run(32'h0080_0000, tok(8'hE1, 11'd7), 3'd0, 12'd0, "R5");
    run(32'h0080_0000, tok(8'h2D, 11'h7FF), 3'd0, 12'd0, "R2");
    // R6 short IN, and the same without detect
    run(32'h2080_0000, tok(8'h69, 11'd7), 3'd0, 12'd7, "R6");
    run(32'h0080_0000, tok(8'h69, 11'd7), 3'd0, 12'd7, "R5");
    run(32'h2080_0000, tok(8'h69, 11'd7), 3'd0, 12'd8, "R6");
    // R7 oversize IN and babble response
    run(32'h0080_0000, tok(8'h69, 11'd7), 3'd0, 12'd9, "R7");
    run(32'h0080_0000, tok(8'hE1, 11'd7), 3'd4, 12'd0, "R7");
    // R8 retry count 3, 1, 0; SETUP NAK; codes above 4
    run(32'h1880_0000, tok(8'hE1, 11'd7), 3'd3, 12'd0, "R8");
    run(32'h0880_0000, tok(8'hE1, 11'd7), 3'd3, 12'd0, "R8");
    run(32'h0080_0000, tok(8'hE1, 11'd7), 3'd3, 12'd0, "R8");
    run(32'h0880_0000, tok(8'h2D, 11'd7), 3'd1, 12'd0, "R8");
    run(32'h1080_0000, tok(8'h69, 11'd7), 3'd6, 12'd0, "R8");
    // R9 NAK on IN keeps active
    run(32'h1880_0000, tok(8'h69, 11'd7), 3'd1, 12'd0, "R9");
    // R10 stall
    run(32'h0080_0000, tok(8'hE1, 11'd7), 3'd2, 12'd0, "R10");
    // R11 isochronous with a NAK
    run(32'h0280_0000, tok(8'h69, 11'd7), 3'd1, 12'd0, "R11");
    // R12 no change gives no write-back
    run(32'h0000_0000, tok(8'h69, 11'd7), 3'd0, 12'd0, "R12");
    check_done_low("R1");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] c, t;
      logic [7:0]  id;
      logic [10:0] mf, mx;
      logic [LW-1:0] n;
      logic [2:0]  r;
      int sel;
      c = $urandom;
      if ($urandom % 4 != 0) c[23] = 1'b1;
      sel = $urandom % 8;
      id = (sel < 3) ? 8'h69 : (sel < 5) ? 8'hE1 : (sel < 7) ? 8'h2D : 8'($urandom);
      mf = ($urandom % 4 == 0) ? 11'h7FF : 11'($urandom % 64);
      mx = mf + 11'd1;
      n = ($urandom % 4 == 0) ? LW'($urandom) : LW'({1'b0, mx} + 12'($urandom % 5)) - LW'(2);
      r = 3'($urandom);
      t = $urandom;
      t[31:21] = mf;
      t[7:0] = id;
      run(c, t, r, n, tag_of(c, t, r, n));
    end
    check_done_low("R1");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule